// File: doc/BRIEF.md
# ARINC 429 Keyed Mailbox Receiver

This block sits behind a serial line front end that has already turned ARINC 429 bit streams into 32-bit words with a one-cycle valid strobe. Each word's low ten bits (eight label bits plus the two source/destination bits) form a key. The key selects one of 1024 single-entry mailboxes. A word is kept only if the host has armed that key's match-enable bit. When a word is kept it replaces the mailbox's contents, the mailbox takes a timestamp from a free-running microsecond counter, and its key is queued in a small notification FIFO. The host walks that FIFO to find out which mailboxes hold fresh data.

Bit 32 of the word (bit 31 in the bus numbering) is an odd-parity bit while checking is on. The host can turn checking off through a control register. Bit 32 is then kept as plain data and no error is raised. A single-cycle register port gives the host access to every mailbox field, the match enables, the FIFO count, the FIFO pop, the parity control and a sticky FIFO-overflow flag.

Top module: `a429mb_rx`

## Requirements
- R1: The mailbox key is word bits [9:0]: label in bits [7:0], source/destination bits in [9:8]. Words that differ only in bits [9:8] go to separate mailboxes. A mailbox field is addressed at host address {1'b0, key[9:0], sel[1:0]}, where sel 0 is status, 1 is data, 2 is timestamp and 3 is match enable (bit 0).
- R2: A valid word whose key has match enable 0 changes nothing: the mailbox status and data stay as they were, and the FIFO count does not change.
- R3: A stored word replaces the mailbox data. Status bit 2 (overwrite) is set to the value the new-data bit had just before the store.
- R4: Each store pushes its key into the FIFO. The count is read at control address {1'b1, 10'b0, 2'd0}. A read at control address sel 1 pops and returns the oldest key in bits [9:0], with bit 31 = 0. When the FIFO is empty that read returns bit 31 = 1 and pops nothing.
- R5: With the parity control bit at 0, a word whose 32 bits have even parity sets status bit 1 (parity error). The word is still stored. A word with odd parity clears that bit.
- R6: With control bit 0 set to 1 (at control address sel 2), no parity error is raised, and bit 31 is stored and read back unchanged as data.
- R7: A host read of a mailbox's data field clears its new-data bit (status bit 0). A status read does not clear it.
- R8: The timestamp field holds the value the microsecond counter had in the cycle the word was accepted. The counter is 0 after reset and advances once every CLK_PER_US clock cycles.
- R9: If a store finds the FIFO full, the sticky overflow flag (bit 0 at control address sel 3) is set, the mailbox is still written, and the count stays at FIFO_DEPTH.
- R10: After reset all status bits, match enables, the parity control bit, the overflow flag and the FIFO count read as 0.
- R11: Read data appears on host_rdata in the cycle after the request. If a data read and a store hit the same mailbox in the same cycle, the read returns the old data and the new-data bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_word holds a received word |
| rx_word | input | 32 | Received ARINC 429 word, bit 31 is word bit 32 |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 13 | Host address: bit 12 selects the control region |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid one cycle after a read |

## Verification
The hardest situation to reach from the ports is a store and a host data read landing on the same mailbox in the same clock cycle, because the clear and the set of the new-data bit then fight over one bit. The bench drives rx_valid and a data read of that key on the same falling edge. It then checks both the returned old data and the status that follows. FIFO overflow is reached by building the bench with a four-entry FIFO and storing five distinct keys without popping.

// File: rtl/a429mb_pkg.sv
package a429mb_pkg;

    localparam int WORD_W  = 32;
    localparam int KEY_W   = 10;
    localparam int SEL_W   = 2;
    localparam int NKEYS   = 1 << KEY_W;
    localparam int HADDR_W = 1 + KEY_W + SEL_W;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STAMP  = 2'd2,
        SEL_MATCH  = 2'd3
    } mb_sel_e;

    typedef enum logic [SEL_W-1:0] {
        CR_COUNT = 2'd0,
        CR_POP   = 2'd1,
        CR_CTRL  = 2'd2,
        CR_FLAGS = 2'd3
    } ctl_sel_e;

    typedef struct packed {
        logic ovr;
        logic perr;
        logic fresh;
    } mb_stat_t;

    typedef struct packed {
        logic  valid;
        key_t  key;
        word_t data;
        logic  perr;
    } rx_acc_t;

    typedef struct packed {
        logic     ctl;
        key_t     key;
        mb_sel_e  sel;
    } haddr_t;

    function automatic logic odd_ok(input word_t w);
        return ^w;
    endfunction

    function automatic key_t key_of(input word_t w);
        return w[KEY_W-1:0];
    endfunction

    function automatic word_t stat_word(input mb_stat_t s);
        return {{(WORD_W-3){1'b0}}, s};
    endfunction

endpackage

// File: rtl/a429mb_tstamp.sv
module a429mb_tstamp #(
    parameter int CLK_PER_US = 50,
    parameter int TS_W       = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts_o
);
    logic [TS_W-1:0] ts_q;
    logic            tick;

    generate
        if (CLK_PER_US <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PS_W = $clog2(CLK_PER_US);
            logic [PS_W-1:0] ps_q;
            assign tick = (ps_q == PS_W'(CLK_PER_US - 1));
            always_ff @(posedge clk) begin
                if (rst)       ps_q <= '0;
                else if (tick) ps_q <= '0;
                else           ps_q <= ps_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       ts_q <= '0;
        else if (tick) ts_q <= ts_q + 1'b1;
    end

    assign ts_o = ts_q;

    AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
        (ts_q == $past(ts_q)) || (ts_q == $past(ts_q) + 1'b1)); // R8

endmodule

// File: rtl/a429mb_screen.sv
module a429mb_screen
    import a429mb_pkg::*;
(
    input  logic    word_valid,
    input  word_t   word,
    input  logic    parity_off,
    output rx_acc_t acc
);
    always_comb begin
        acc.valid = word_valid;
        acc.key   = key_of(word);
        acc.data  = word;
        acc.perr  = !parity_off && !odd_ok(word);
    end
endmodule

// File: rtl/a429mb_store.sv
module a429mb_store
    import a429mb_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  rx_acc_t         acc,
    input  logic [TS_W-1:0] ts,
    input  key_t            h_key,
    input  mb_sel_e         h_sel,
    input  logic            h_clr_fresh,
    input  logic            h_match_we,
    input  logic            h_match_bit,
    output logic            stored,
    output word_t           h_word
);
    logic [NKEYS-1:0] en_q;
    logic [NKEYS-1:0] fresh_q;
    logic [NKEYS-1:0] perr_q;
    logic [NKEYS-1:0] ovr_q;
    word_t            data_q  [NKEYS];
    logic [TS_W-1:0]  stamp_q [NKEYS];

    assign stored = acc.valid && en_q[acc.key];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            fresh_q <= '0;
            perr_q  <= '0;
            ovr_q   <= '0;
        end else begin
            if (h_match_we)
                en_q[h_key] <= h_match_bit;
            if (h_clr_fresh)
                fresh_q[h_key] <= 1'b0;
            if (stored) begin
                fresh_q[acc.key] <= 1'b1;
                ovr_q[acc.key]   <= fresh_q[acc.key];
                perr_q[acc.key]  <= acc.perr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (stored) begin
            data_q[acc.key]  <= acc.data;
            stamp_q[acc.key] <= ts;
        end
    end

    always_comb begin
        mb_stat_t s;
        s.ovr   = ovr_q[h_key];
        s.perr  = perr_q[h_key];
        s.fresh = fresh_q[h_key];
        case (h_sel)
            SEL_STATUS: h_word = stat_word(s);
            SEL_DATA:   h_word = data_q[h_key];
            SEL_STAMP:  h_word = WORD_W'(stamp_q[h_key]);
            default:    h_word = {{(WORD_W-1){1'b0}}, en_q[h_key]};
        endcase
    end

    AST_OVR_ON_REFILL: assert property (@(posedge clk) disable iff (rst)
        (stored && fresh_q[acc.key]) |=> ovr_q[$past(acc.key)]); // R3

    AST_DROP_UNMATCHED: assert property (@(posedge clk) disable iff (rst)
        (acc.valid && !en_q[acc.key] && !(h_clr_fresh && h_key == acc.key))
        |=> (fresh_q[$past(acc.key)] == $past(fresh_q[acc.key]))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (h_clr_fresh && !(stored && acc.key == h_key))
        |=> !fresh_q[$past(h_key)]); // R7

    AST_STORE_WINS: assert property (@(posedge clk) disable iff (rst)
        stored |=> fresh_q[$past(acc.key)]); // R11

endmodule

// File: rtl/a429mb_keyfifo.sv
module a429mb_keyfifo
    import a429mb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  key_t                       push_key,
    input  logic                       pop,
    output key_t                       head,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    key_t             mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full, do_pop, do_push;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push && !do_push) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_key;
    end

    assign head  = mem_q[rd_q];
    assign count = cnt_q;
    assign ovf   = ovf_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R9

    AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ovf_q); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
        || (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/a429mb_rx.sv
module a429mb_rx
    import a429mb_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_PER_US = 50,
    parameter int TS_W       = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [31:0]        rx_word,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    haddr_t           ha;
    rx_acc_t          acc;
    logic [TS_W-1:0]  ts;
    logic             parity_off_q;
    logic             stored;
    word_t            mb_word, ctl_word, rdata_q;
    key_t             head;
    logic             empty, ovf;
    logic [CNT_W-1:0] count;
    logic             h_rd, h_wr, clr_fresh, match_we, pop;

    assign ha        = haddr_t'(host_addr);
    assign h_rd      = host_en && !host_we;
    assign h_wr      = host_en && host_we;
    assign clr_fresh = h_rd && !ha.ctl && ha.sel == SEL_DATA;
    assign match_we  = h_wr && !ha.ctl && ha.sel == SEL_MATCH;
    assign pop       = h_rd && ha.ctl && ctl_sel_e'(ha.sel) == CR_POP;

    a429mb_tstamp #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W)) u_ts (
        .clk (clk),
        .rst (rst),
        .ts_o(ts)
    );

    a429mb_screen u_screen (
        .word_valid(rx_valid),
        .word      (rx_word),
        .parity_off(parity_off_q),
        .acc       (acc)
    );

    a429mb_store #(.TS_W(TS_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .ts         (ts),
        .h_key      (ha.key),
        .h_sel      (ha.sel),
        .h_clr_fresh(clr_fresh),
        .h_match_we (match_we),
        .h_match_bit(host_wdata[0]),
        .stored     (stored),
        .h_word     (mb_word)
    );

    a429mb_keyfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (stored),
        .push_key(acc.key),
        .pop     (pop),
        .head    (head),
        .empty   (empty),
        .count   (count),
        .ovf     (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) parity_off_q <= 1'b0;
        else if (h_wr && ha.ctl && ctl_sel_e'(ha.sel) == CR_CTRL)
            parity_off_q <= host_wdata[0];
    end

    always_comb begin
        case (ctl_sel_e'(ha.sel))
            CR_COUNT: ctl_word = WORD_W'(count);
            CR_POP:   ctl_word = empty ? {1'b1, {(WORD_W-1){1'b0}}}
                                       : WORD_W'(head);
            CR_CTRL:  ctl_word = WORD_W'(parity_off_q);
            default:  ctl_word = WORD_W'(ovf);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (h_rd) rdata_q <= ha.ctl ? ctl_word : mb_word;
    end

    assign host_rdata = rdata_q;

    AST_PARITY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !parity_off_q && !odd_ok(rx_word)) |-> acc.perr); // R5

    AST_PARITY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && parity_off_q) |-> !acc.perr); // R6

endmodule

// File: tb/a429mb_rx_test.sv
`timescale 1ns/1ps
module a429mb_rx_test;

    localparam int DEPTH = 4;
    localparam int PS    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int edges = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    a429mb_rx #(.FIFO_DEPTH(DEPTH), .CLK_PER_US(PS), .TS_W(32)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic [12:0] mba(input logic [9:0] k, input logic [1:0] s);
        return {1'b0, k, s};
    endfunction
    function automatic logic [12:0] cra(input logic [1:0] s);
        return {1'b1, 10'd0, s};
    endfunction
    function automatic logic [31:0] good(input logic [30:0] x);
        return {~^x, x};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_valid = 1'b0; host_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hw(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hr(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic send(input logic [31:0] w, output int exp_ts);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w;
        exp_ts = edges / PS;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        hr(mba(10'h123, 2'd0), d); check("R10 status", d, 0);
        hr(mba(10'h123, 2'd3), d); check("R10 match", d, 0);
        hr(cra(2'd0), d);          check("R10 count", d, 0);
        hr(cra(2'd2), d);          check("R10 ctrl", d, 0);
        hr(cra(2'd3), d);          check("R10 flags", d, 0);
        hr(cra(2'd1), d);          check("R4 empty pop", d, 32'h8000_0000);
    endtask

    task automatic t_basic();
        logic [31:0] d, w;
        int ts;
        do_reset();
        w = good(31'h1234_52A5);
        hw(mba(10'h2A5, 2'd3), 1);
        hr(mba(10'h2A5, 2'd3), d); check("R1 match readback", d, 1);
        send(w, ts);
        hr(mba(10'h2A5, 2'd0), d); check("R2 stored status", d, 1);
        hr(mba(10'h2A5, 2'd0), d); check("R7 status read keeps new", d, 1);
        hr(cra(2'd0), d);          check("R4 count one", d, 1);
        hr(mba(10'h2A5, 2'd1), d); check("R1 data", d, w);
        hr(mba(10'h2A5, 2'd0), d); check("R7 data read clears", d, 0);
        hr(cra(2'd1), d);          check("R4 pop key", d, 32'h2A5);
        hr(cra(2'd0), d);          check("R4 count after pop", d, 0);
    endtask

    task automatic t_filter();
        logic [31:0] d;
        int ts;
        do_reset();
        hw(mba(10'h0A5, 2'd3), 1);
        send(good(31'h0000_01A5), ts);
        hr(mba(10'h1A5, 2'd0), d); check("R2 unmatched status", d, 0);
        hr(mba(10'h0A5, 2'd0), d); check("R1 other SDI untouched", d, 0);
        hr(cra(2'd0), d);          check("R2 unmatched count", d, 0);
        hw(mba(10'h1A5, 2'd3), 1);
        send(good(31'h0000_05A5), ts);
        hr(mba(10'h1A5, 2'd0), d); check("R1 SDI mailbox status", d, 1);
        hr(mba(10'h0A5, 2'd0), d); check("R1 SDI sibling status", d, 0);
    endtask

    task automatic t_overwrite();
        logic [31:0] d, w1, w2;
        int ts;
        do_reset();
        w1 = good(31'h0011_0077);
        w2 = good(31'h0022_0077);
        hw(mba(10'h077, 2'd3), 1);
        send(w1, ts);
        hr(mba(10'h077, 2'd0), d); check("R3 first no ovr", d, 1);
        send(w2, ts);
        hr(mba(10'h077, 2'd0), d); check("R3 ovr set", d, 5);
        hr(mba(10'h077, 2'd1), d); check("R3 newest data", d, w2);
        hr(cra(2'd0), d);          check("R3 two keys queued", d, 2);
        send(w1, ts);
        hr(mba(10'h077, 2'd0), d); check("R3 ovr after read clear", d, 1);
    endtask

    task automatic t_order();
        logic [31:0] d;
        int ts;
        do_reset();
        hw(mba(10'h011, 2'd3), 1);
        hw(mba(10'h322, 2'd3), 1);
        hw(mba(10'h133, 2'd3), 1);
        send(good(31'h0000_0322), ts);
        send(good(31'h0000_0011), ts);
        send(good(31'h0000_0133), ts);
        hr(cra(2'd0), d); check("R4 count three", d, 3);
        hr(cra(2'd1), d); check("R4 order 1", d, 32'h322);
        hr(cra(2'd1), d); check("R4 order 2", d, 32'h011);
        hr(cra(2'd1), d); check("R4 order 3", d, 32'h133);
        hr(cra(2'd1), d); check("R4 drained", d, 32'h8000_0000);
    endtask

    task automatic t_parity();
        logic [31:0] d, bad;
        int ts;
        do_reset();
        hw(mba(10'h0F0, 2'd3), 1);
        hw(mba(10'h0F1, 2'd3), 1);
        bad = good(31'h0ABC_00F0) ^ 32'h8000_0000;
        send(bad, ts);
        send(good(31'h0ABC_00F1), ts);
        hr(mba(10'h0F0, 2'd0), d); check("R5 bad parity flag", d, 3);
        hr(mba(10'h0F0, 2'd1), d); check("R5 bad word kept", d, bad);
        hr(mba(10'h0F1, 2'd0), d); check("R5 good parity", d, 1);
        send(good(31'h0ABC_00F0), ts);
        hr(mba(10'h0F0, 2'd0), d); check("R5 flag cleared by good word", d, 1);
    endtask

    task automatic t_parity_off();
        logic [31:0] d, bad;
        int ts;
        do_reset();
        hw(cra(2'd2), 1);
        hr(cra(2'd2), d); check("R6 ctrl readback", d, 1);
        hw(mba(10'h0F0, 2'd3), 1);
        bad = good(31'h0ABC_00F0) ^ 32'h8000_0000;
        send(bad, ts);
        hr(mba(10'h0F0, 2'd0), d); check("R6 no parity flag", d, 1);
        hr(mba(10'h0F0, 2'd1), d); check("R6 bit 32 as data", d, bad);
    endtask

    task automatic t_stamp();
        logic [31:0] d;
        int ts1, ts2;
        do_reset();
        hw(mba(10'h040, 2'd3), 1);
        hw(mba(10'h041, 2'd3), 1);
        repeat (9) @(negedge clk);
        send(good(31'h0000_0040), ts1);
        repeat (23) @(negedge clk);
        send(good(31'h0000_0041), ts2);
        hr(mba(10'h040, 2'd2), d); check("R8 stamp first", d, ts1);
        hr(mba(10'h041, 2'd2), d); check("R8 stamp second", d, ts2);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int ts;
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) hw(mba(10'(i + 8), 2'd3), 1);
        for (int i = 0; i < DEPTH + 1; i++) send(good(31'(i + 8)), ts);
        hr(cra(2'd3), d); check("R9 overflow flag", d, 1);
        hr(cra(2'd0), d); check("R9 count at depth", d, DEPTH);
        hr(mba(10'(DEPTH + 8), 2'd0), d); check("R9 last mailbox written", d, 1);
        hr(cra(2'd1), d); check("R9 first key kept", d, 8);
        hr(cra(2'd3), d); check("R9 flag sticky", d, 1);
    endtask

    task automatic t_collide();
        logic [31:0] d, w1, w2;
        int ts;
        do_reset();
        w1 = good(31'h0055_0199);
        w2 = good(31'h0066_0199);
        hw(mba(10'h199, 2'd3), 1);
        send(w1, ts);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w2;
        host_en = 1'b1; host_we = 1'b0; host_addr = mba(10'h199, 2'd1);
        @(negedge clk);
        rx_valid = 1'b0; host_en = 1'b0;
        check("R11 collide returns old data", host_rdata, w1);
        hr(mba(10'h199, 2'd0), d); check("R11 new bit survives", d, 5);
        hr(mba(10'h199, 2'd1), d); check("R11 newer data kept", d, w2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_filter();
        t_overwrite();
        t_order();
        t_parity();
        t_parity_off();
        t_stamp();
        t_overflow();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule